// File: doc/BRIEF.md
# Periodic Tick Timer with Limit Flag

This block is a periodic system timer reached over a simple 32-bit register bus. Once launched, a count register advances by one on every clock in which the tick-enable input is high. That input is nominally a 10 MHz enable, one tick per 100 ns. When the count reaches the programmed limit, it reloads the programmed start value on that same tick and raises a limit event.

Each limit event is reported in the top bit of the counter register and on an interrupt pin. In the normal mode the flag is a sticky bit that a read of the counter register clears, and the interrupt is a level that follows the flag. In the invert mode the flag toggles on every event, starting from an initial state chosen at launch, and the interrupt becomes a one-clock pulse per event.

The bus has no back-pressure. A request is accepted in the cycle that `bus_en` is high, and read data always returns exactly one cycle later, marked by `bus_rvalid`.

Top module: `tick_timer`

## Requirements
- R1: After reset the limit, start, counter and control registers all read as zero, and `irq` is low.
- R2: The limit register sits at offset 0x00, the start register at 0x04 and the counter register at 0x08. Each holds its count in bits 30:9. Bits 8:0 read as zero and ignore writes, and bit 31 of the limit and start registers reads as zero. Any other offset reads as zero.
- R3: The control register sits at offset 0x0c. Bit 0 is run, bit 1 is invert mode and bit 2 is the initial flag state, and the register reads back as written. A control write with bit 0 set is a launch: it loads the start value into the counter and sets the flag to bit 2. With run at 0 the counter holds its value.
- R4: While running, the counter increments by one at each clock edge where `tick_enable` is high, and it does not change on edges where `tick_enable` is low.
- R5: A tick that finds the counter equal to the limit reloads the start value on that same edge and produces a limit event.
- R6: In normal mode (control bit 1 = 0), a limit event sets bit 31 of the counter register. A read of offset 0x08 returns the flag and then clears it.
- R7: In normal mode, `irq` is high exactly while the limit flag is set.
- R8: In invert mode (control bit 1 = 1), each limit event inverts the flag, and reads do not clear it.
- R9: In invert mode, `irq` is high for the single clock after each limit event and low otherwise, whatever the flag holds.
- R10: Read data appears on `bus_rdata` together with `bus_rvalid` one clock after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_enable | input | 1 | Count enable, one pulse per timer tick |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Marks the cycle that carries read data |
| irq | output | 1 | Limit interrupt, a level or a pulse depending on the mode |

## Verification
A register write takes effect at the clock edge that accepts it. Read data and `bus_rvalid` are due one edge after the request, and a read that clears the flag drops `irq` at that same edge. Count, reload and flag changes happen at the edge that carries the tick, and the invert-mode interrupt pulse is visible only for the cycle after that edge. The bench drives every input on the falling edge and samples on the next falling edge, after exactly the number of rising edges each result needs. Ticks are gated per cycle, so the bench knows the count it expects at every step.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned OFF_LIMIT = 'h00;
  localparam int unsigned OFF_START = 'h04;
  localparam int unsigned OFF_COUNT = 'h08;
  localparam int unsigned OFF_CTRL  = 'h0c;

  localparam int CTL_RUN_BIT   = 0;
  localparam int CTL_INV_BIT   = 1;
  localparam int CTL_FINIT_BIT = 2;

  typedef struct packed {
    logic finit;
    logic inv;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int CNT_LSB = 9,
  parameter int CNT_W   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              flag_q,
  output logic [CNT_W-1:0]  limit_q,
  output logic [CNT_W-1:0]  start_q,
  output ctrl_t             ctrl_q,
  output logic              launch,
  output logic              launch_finit,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wval,
  output logic              cnt_rd
);
  logic wr, rd, hit_lim, hit_sta, hit_cnt, hit_ctl;
  logic [DATA_W-1:0] rd_mux;
  logic wdata_unused;

  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;
  assign hit_lim = (bus_addr == ADDR_W'(OFF_LIMIT));
  assign hit_sta = (bus_addr == ADDR_W'(OFF_START));
  assign hit_cnt = (bus_addr == ADDR_W'(OFF_COUNT));
  assign hit_ctl = (bus_addr == ADDR_W'(OFF_CTRL));

  assign cnt_wval     = bus_wdata[CNT_LSB +: CNT_W];
  assign launch       = wr & hit_ctl & bus_wdata[CTL_RUN_BIT];
  assign launch_finit = bus_wdata[CTL_FINIT_BIT];
  assign cnt_wr       = wr & hit_cnt;
  assign cnt_rd       = rd & hit_cnt;
  assign wdata_unused = ^{bus_wdata[DATA_W-1], bus_wdata[CNT_LSB-1:3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q <= '0;
      start_q <= '0;
      ctrl_q  <= '0;
    end else if (wr) begin
      if (hit_lim) limit_q <= cnt_wval;
      if (hit_sta) start_q <= cnt_wval;
      if (hit_ctl) begin
        ctrl_q.run   <= bus_wdata[CTL_RUN_BIT];
        ctrl_q.inv   <= bus_wdata[CTL_INV_BIT];
        ctrl_q.finit <= bus_wdata[CTL_FINIT_BIT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_lim) rd_mux = {1'b0, limit_q, {CNT_LSB{1'b0}}};
    if (hit_sta) rd_mux = {1'b0, start_q, {CNT_LSB{1'b0}}};
    if (hit_cnt) rd_mux = {flag_q, cnt_q, {CNT_LSB{1'b0}}};
    if (hit_ctl) rd_mux = DATA_W'(ctrl_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_mux : '0;
    end
  end

  // R10: a read request returns valid data on the following edge
  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> bus_rvalid);
  // R3: a launch leaves the timer running
  p_launch_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> ctrl_q.run);
endmodule

// File: rtl/timer_count.sv
module timer_count #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] limit_q,
  input  logic [CNT_W-1:0] start_q,
  input  logic             launch,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wval,
  output logic [CNT_W-1:0] cnt_q,
  output logic             evt
);
  logic at_lim, adv;

  assign at_lim = (cnt_q == limit_q);
  assign adv    = run & tick & ~launch & ~cnt_wr;
  assign evt    = adv & at_lim;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (launch) cnt_q <= start_q;
    else if (cnt_wr) cnt_q <= cnt_wval;
    else if (adv)    cnt_q <= at_lim ? start_q : cnt_q + CNT_W'(1);
  end

  // R4: a tick below the limit adds exactly one
  p_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !launch && !cnt_wr && cnt_q != limit_q) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R5: a tick at the limit brings back the start value
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !launch && !cnt_wr && cnt_q == limit_q) |=> cnt_q == $past(start_q));
  // R3: a stopped counter holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !launch && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/timer_flag.sv
module timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic inv,
  input  logic launch,
  input  logic launch_finit,
  input  logic cnt_rd,
  output logic flag_q,
  output logic irq
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= evt;
      if (launch)            flag_q <= launch_finit;
      else if (evt)          flag_q <= inv ? ~flag_q : 1'b1;
      else if (cnt_rd && !inv) flag_q <= 1'b0;
    end
  end

  assign irq = inv ? pulse_q : flag_q;

  // R6: a normal-mode event sets the flag
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv && evt) |=> flag_q);
  // R6: a normal-mode counter read clears the flag
  p_rdclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv && cnt_rd && !evt && !launch) |=> !flag_q);
  // R8: an invert-mode event flips the flag
  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv && evt) |=> flag_q != $past(flag_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int CNT_LSB = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_enable,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  localparam int CNT_W = DATA_W - 1 - CNT_LSB;

  logic [CNT_W-1:0] cnt_q, limit_q, start_q, cnt_wval;
  ctrl_t ctrl_q;
  logic launch, launch_finit, cnt_wr, cnt_rd, evt, flag_q;

  timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cnt_q(cnt_q), .flag_q(flag_q), .limit_q(limit_q), .start_q(start_q), .ctrl_q(ctrl_q),
    .launch(launch), .launch_finit(launch_finit), .cnt_wr(cnt_wr), .cnt_wval(cnt_wval),
    .cnt_rd(cnt_rd));

  timer_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_enable), .run(ctrl_q.run), .limit_q(limit_q),
    .start_q(start_q), .launch(launch), .cnt_wr(cnt_wr), .cnt_wval(cnt_wval),
    .cnt_q(cnt_q), .evt(evt));

  timer_flag flag_i (
    .clk(clk), .rst_n(rst_n), .evt(evt), .inv(ctrl_q.inv), .launch(launch),
    .launch_finit(launch_finit), .cnt_rd(cnt_rd), .flag_q(flag_q), .irq(irq));

  // R7: in normal mode the interrupt never rises without a limit event
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.inv && !irq && !launch) |=> (irq |-> $past(evt)));
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_enable = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_timer dut_i (.clk(clk), .rst_n(rst_n), .tick_enable(tick_enable), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq));

  function automatic logic [31:0] cval(int v, bit f);
    return {f, 22'(v), 9'b0};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); @(negedge clk); bus_en = 0;
    checks++;
    if (bus_rvalid !== 1'b1) begin failures++; $display("FAIL R10 rvalid got=%b exp=1", bus_rvalid); end
    d = bus_rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick_enable = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick_enable = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 0);
    rd('h0, d); check("R1 limit", d, 0);
    rd('h4, d); check("R1 start", d, 0);
    rd('h8, d); check("R1 count", d, 0);
    rd('hc, d); check("R1 ctrl", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr('h0, 32'h8000_0000 | cval(50, 0) | 32'h1ff); rd('h0, d); check("R2 limit low bits", d, cval(50, 0));
    wr('h4, cval(10, 0) | 32'h5); rd('h4, d); check("R2 start", d, cval(10, 0));
    rd('h2, d); check("R2 unmapped", d, 0);
    wr('h0, cval(13, 0)); rd('h0, d); check("R2 limit", d, cval(13, 0));
  endtask

  task automatic t_normal();
    logic [31:0] d;
    wr('hc, 32'h1); rd('h8, d); check("R3 launch loads start", d, cval(10, 0));
    repeat (5) @(negedge clk);
    rd('h8, d); check("R4 no tick no change", d, cval(10, 0));
    ticks(2); rd('h8, d); check("R4 two ticks", d, cval(12, 0));
    ticks(1); check("R7 irq low before event", 32'(irq), 0);
    ticks(1); check("R7 irq high on flag", 32'(irq), 1);
    rd('h8, d); check("R5 R6 reload and flag", d, cval(10, 1));
    check("R7 irq drops after read", 32'(irq), 0);
    rd('h8, d); check("R6 flag cleared", d, cval(10, 0));
    wr('hc, 32'h0); ticks(3); rd('h8, d); check("R3 stopped holds", d, cval(10, 0));
  endtask

  task automatic t_invert();
    logic [31:0] d;
    wr('hc, 32'h7); rd('hc, d); check("R3 ctrl readback", d, 32'h7);
    rd('h8, d); check("R3 initial flag 1", d, cval(10, 1));
    rd('h8, d); check("R8 read keeps flag", d, cval(10, 1));
    check("R9 irq low with flag set", 32'(irq), 0);
    ticks(3); check("R9 no pulse before event", 32'(irq), 0);
    ticks(1); check("R9 pulse after event", 32'(irq), 1);
    @(negedge clk); check("R9 pulse one clock", 32'(irq), 0);
    rd('h8, d); check("R8 flag toggled to 0", d, cval(10, 0));
    ticks(4); rd('h8, d); check("R8 flag toggled to 1", d, cval(10, 1));
    wr('hc, 32'h3); rd('h8, d); check("R3 initial flag 0", d, cval(10, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_normal();
    t_invert();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule